// File: doc/BRIEF.md
# Table-Driven DMA Slot Scheduler

This block decides which DMA channel, and in which direction, is offered each transfer slot. Software fills a table of one-byte entries, four to a 32-bit word. Each entry names a channel and says whether the slot is for transmit or for receive. Software then sets the enable bit and the index of the last valid entry in a control register.

While enabled, the block walks the table one entry per clock. It starts at entry 0 and wraps back to entry 0 after the last valid entry. A slot whose channel and direction has a request pending produces a one-cycle grant carrying the channel number and the direction. A slot with no pending request produces nothing, and the walk still moves on. The data movers that act on a grant are outside this block.

Software clears the enable bit before it rewrites the table. Everything it writes can be read back through the same register port.

Top module: `slot_sched_table`

## Requirements
- R1: Table word i is at byte address 0x800 + 4*i, for i from 0 to 15. Writes to it are stored and can be read back unchanged. Entry k of a word occupies bits [8k+7:8k], so entry number 4*i + k lives in word i, byte k.
- R2: The control register is at address 0x000. Bit 31 is the enable. Bits [5:0] hold the index of the last valid entry (entry count minus one). Reading it returns these fields, with zeros in bits [30:6].
- R3: Writes to any other address change no register. Reads of any other address return zero.
- R4: After a write sets the enable, entry 0 is evaluated at the next clock edge, and entry k at the (k+1)-th edge after the write. Each evaluation places its result on the grant outputs for exactly one cycle.
- R5: In an entry, bits [4:0] give the channel. Bit 7 set means receive, and bit 7 clear means transmit. Bits [6:5] are ignored. A grant goes out, with gnt_ch equal to the channel and gnt_rx equal to bit 7, when rx_req[ch] (for receive) or tx_req[ch] (for transmit) was high in the cycle the entry was evaluated.
- R6: An entry whose request is low gives gnt_vld = 0 in its slot, and the next entry is still evaluated in the following slot.
- R7: After the entry at the last valid index, the next slot evaluates entry 0.
- R8: Clearing the enable stops the walk. From the second clock edge after that write, gnt_vld stays 0 and the position returns to entry 0, so that a later enable starts again from entry 0.
- R9: After reset, gnt_vld is 0, the control register reads 0 and every table word reads 0.
- R10: gnt_vld is asserted only for a channel and direction whose request input was high in the preceding cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte address, for both reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| tx_req | input | 32 | Per-channel transmit request |
| rx_req | input | 32 | Per-channel receive request |
| gnt_vld | output | 1 | One-cycle grant strobe |
| gnt_ch | output | 5 | Granted channel |
| gnt_rx | output | 1 | Granted direction: 1 receive, 0 transmit |

## Verification
Register writes take effect at the edge that samples the strobe, and the combinational read path shows the result right after it. A grant is registered, so the result for entry k appears k+1 edges after the enabling write edge, and a disable is only guaranteed from the second edge after it. The bench drives on falling edges, and each write task returns on the falling edge just after the write. It then counts falling edges from that point: slot k is sampled at the (k+1)-th falling edge. The first sample after a disable is skipped on purpose, because in that cycle a grant may still legally appear.

// File: rtl/sched_pkg.sv
package sched_pkg;
   localparam int unsigned CTRL_OFS     = 32'h000;
   localparam int unsigned TBL_OFS      = 32'h800;
   localparam int unsigned ENT_W        = 8;
   localparam int unsigned ENT_PER_WORD = 4;
   localparam int unsigned ENT_DIR_BIT  = 7;
   localparam int unsigned CTRL_EN_BIT  = 31;
endpackage

// File: rtl/sched_regs.sv
module sched_regs
   import sched_pkg::*;
#(
   parameter int unsigned TBL_WORDS = 16,
   parameter int unsigned ADDR_W    = 12,
   parameter int unsigned IDX_W     = $clog2(TBL_WORDS * ENT_PER_WORD)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic [31:0]       wdata,
   output logic [31:0]       rdata,
   output logic              en,
   output logic [IDX_W-1:0]  last,
   input  logic [IDX_W-1:0]  ent_idx,
   output logic [ENT_W-1:0]  ent
);
   localparam int unsigned WI_W = $clog2(TBL_WORDS);
   localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(TBL_OFS);
   localparam logic [ADDR_W-1:0] SPAN_A = ADDR_W'(TBL_WORDS * 4);
   localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_OFS);

   if ((TBL_WORDS < 2) || ((TBL_WORDS & (TBL_WORDS - 1)) != 0)) begin : g_bad_words
      $error("TBL_WORDS must be a power of two, at least 2");
   end
   if (TBL_OFS + TBL_WORDS * 4 > (1 << ADDR_W)) begin : g_bad_addr
      $error("table does not fit in the address space");
   end
   if (IDX_W > CTRL_EN_BIT) begin : g_bad_idx
      $error("last-index field overlaps the enable bit");
   end

   logic [31:0]         tbl_q [TBL_WORDS];
   logic [ADDR_W-1:0]   tbl_off;
   logic                tbl_hit;
   logic                ctrl_hit;
   logic [WI_W-1:0]     widx;

   assign tbl_off  = addr - BASE_A;
   assign tbl_hit  = (addr >= BASE_A) && (tbl_off < SPAN_A) && (addr[1:0] == 2'b00);
   assign ctrl_hit = (addr == CTRL_A);
   assign widx     = tbl_off[WI_W+1:2];

   for (genvar gi = 0; gi < TBL_WORDS; gi++) begin : g_word
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            tbl_q[gi] <= '0;
         else if (wr && tbl_hit && (widx == WI_W'(gi)))
            tbl_q[gi] <= wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en   <= 1'b0;
         last <= '0;
      end else if (wr && ctrl_hit) begin
         en   <= wdata[CTRL_EN_BIT];
         last <= wdata[IDX_W-1:0];
      end
   end

   always_comb begin
      rdata = '0;
      if (ctrl_hit) begin
         rdata[CTRL_EN_BIT] = en;
         rdata[IDX_W-1:0]   = last;
      end else if (tbl_hit) begin
         rdata = tbl_q[widx];
      end
   end

   logic [31:0] cur_word;
   assign cur_word = tbl_q[ent_idx[IDX_W-1:2]];
   assign ent      = cur_word[ENT_W*ent_idx[1:0] +: ENT_W];

   // R2: a control write lands in the enable and last-index state one edge later
   a_r2_ctrl_load: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && ctrl_hit) |=> (en == $past(wdata[CTRL_EN_BIT]) && last == $past(wdata[IDX_W-1:0])));
   // R3: no write strobe, word 0 keeps its value
   a_r3_word_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !wr |=> $stable(tbl_q[0]));
   // R1: a write to word 0 is stored in full
   a_r1_word_store: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && addr == BASE_A) |=> (tbl_q[0] == $past(wdata)));
endmodule

// File: rtl/sched_walker.sv
module sched_walker
   import sched_pkg::*;
#(
   parameter int unsigned NUM_CH = 32,
   parameter int unsigned CH_W   = $clog2(NUM_CH),
   parameter int unsigned IDX_W  = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic [IDX_W-1:0]  last,
   input  logic [ENT_W-1:0]  ent,
   input  logic [NUM_CH-1:0] tx_req,
   input  logic [NUM_CH-1:0] rx_req,
   output logic [IDX_W-1:0]  ptr,
   output logic              gnt_vld,
   output logic [CH_W-1:0]   gnt_ch,
   output logic              gnt_rx
);
   if (CH_W > ENT_DIR_BIT) begin : g_bad_ch
      $error("channel field collides with the direction bit");
   end

   logic [CH_W-1:0] ent_ch;
   logic            ent_rx;
   logic            ch_ok;
   logic            req_hit;

   assign ent_ch  = ent[CH_W-1:0];
   assign ent_rx  = ent[ENT_DIR_BIT];
   assign ch_ok   = (int'(ent_ch) < NUM_CH);
   assign req_hit = ch_ok && (ent_rx ? rx_req[ent_ch] : tx_req[ent_ch]);

   if (CH_W < ENT_DIR_BIT) begin : g_pad
      logic unused_pad;
      assign unused_pad = ^ent[ENT_DIR_BIT-1:CH_W];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr     <= '0;
         gnt_vld <= 1'b0;
         gnt_ch  <= '0;
         gnt_rx  <= 1'b0;
      end else begin
         if (!en || (ptr >= last))
            ptr <= '0;
         else
            ptr <= ptr + 1'b1;
         gnt_vld <= en && req_hit;
         gnt_ch  <= ent_ch;
         gnt_rx  <= ent_rx;
      end
   end

   logic [NUM_CH-1:0] tx_req_d, rx_req_d;
   logic              en_d;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_req_d <= '0;
         rx_req_d <= '0;
         en_d     <= 1'b0;
      end else begin
         tx_req_d <= tx_req;
         rx_req_d <= rx_req;
         en_d     <= en;
      end
   end

   // R10: a grant names a request that was present one cycle earlier
   a_r10_gnt_had_req: assert property (@(posedge clk) disable iff (!rst_n)
      gnt_vld |-> (gnt_rx ? rx_req_d[gnt_ch] : tx_req_d[gnt_ch]));
   // R8: with the enable low in the previous cycle, no grant is present
   a_r8_off_no_gnt: assert property (@(posedge clk) disable iff (!rst_n)
      !en_d |-> !gnt_vld);
   // R8: disabled, the position returns to entry 0
   a_r8_off_ptr_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (ptr == '0));
   // R7: the entry after the last index is entry 0
   a_r7_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (en && ptr == last) |=> (ptr == '0));
   // R4, R6: one entry per slot, whether or not a grant was given
   a_r4_step: assert property (@(posedge clk) disable iff (!rst_n)
      (en && ptr < last) |=> (ptr == $past(ptr) + 1'b1));
endmodule

// File: rtl/slot_sched_table.sv
module slot_sched_table
   import sched_pkg::*;
#(
   parameter int unsigned NUM_CH    = 32,
   parameter int unsigned TBL_WORDS = 16,
   parameter int unsigned ADDR_W    = 12,
   localparam int unsigned CH_W     = $clog2(NUM_CH),
   localparam int unsigned IDX_W    = $clog2(TBL_WORDS * ENT_PER_WORD)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   input  logic [NUM_CH-1:0] tx_req,
   input  logic [NUM_CH-1:0] rx_req,
   output logic              gnt_vld,
   output logic [CH_W-1:0]   gnt_ch,
   output logic              gnt_rx
);
   if (NUM_CH < 2) begin : g_bad_ch
      $error("NUM_CH must be at least 2");
   end

   logic             en;
   logic [IDX_W-1:0] last;
   logic [IDX_W-1:0] ptr;
   logic [ENT_W-1:0] ent;

   sched_regs #(
      .TBL_WORDS (TBL_WORDS),
      .ADDR_W    (ADDR_W),
      .IDX_W     (IDX_W)
   ) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr      (reg_wr),
      .addr    (reg_addr),
      .wdata   (reg_wdata),
      .rdata   (reg_rdata),
      .en      (en),
      .last    (last),
      .ent_idx (ptr),
      .ent     (ent)
   );

   sched_walker #(
      .NUM_CH (NUM_CH),
      .CH_W   (CH_W),
      .IDX_W  (IDX_W)
   ) u_walk (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (en),
      .last    (last),
      .ent     (ent),
      .tx_req  (tx_req),
      .rx_req  (rx_req),
      .ptr     (ptr),
      .gnt_vld (gnt_vld),
      .gnt_ch  (gnt_ch),
      .gnt_rx  (gnt_rx)
   );
endmodule

// File: tb/slot_sched_table_bench.sv
`timescale 1ns/1ps
module slot_sched_table_bench;
   localparam time HALF = 10ns;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [11:0] reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [31:0] tx_req = '0;
   logic [31:0] rx_req = '0;
   logic        gnt_vld;
   logic [4:0]  gnt_ch;
   logic        gnt_rx;

   int checks = 0;
   int fails  = 0;

   always #HALF clk = ~clk;

   slot_sched_table u_slot_sched_table (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_req(tx_req),
      .rx_req(rx_req), .gnt_vld(gnt_vld), .gnt_ch(gnt_ch), .gnt_rx(gnt_rx)
   );

   // Expected result per slot: {vld, rx, ch}. The table is
   // 00 81 01 80 1F E4 02 9F, with tx_req = ch0,2,31 and rx_req = ch1,4.
   localparam logic [6:0] SLOT_EXP [10] = '{
      7'b1_0_00000, 7'b1_1_00001, 7'b0_0_00000, 7'b0_0_00000, 7'b1_0_11111,
      7'b1_1_00100, 7'b1_0_00010, 7'b0_0_00000, 7'b1_0_00000, 7'b1_1_00001
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic reg_write(input logic [11:0] a, input logic [31:0] d);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic reg_read(input logic [11:0] a, output logic [31:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic finish_run;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      logic [31:0] rd;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R9 reset state
      check("R9 gnt_vld", {31'b0, gnt_vld}, 32'h0);
      reg_read(12'h000, rd); check("R9 ctrl", rd, 32'h0);
      reg_read(12'h804, rd); check("R9 table", rd, 32'h0);

      // R1 load and read back
      reg_write(12'h800, 32'h8001_8100);
      reg_write(12'h804, 32'h9F02_E41F);
      reg_read(12'h800, rd); check("R1 word0", rd, 32'h8001_8100);
      reg_read(12'h804, rd); check("R1 word1", rd, 32'h9F02_E41F);

      // R3 unmapped access
      reg_write(12'h400, 32'hDEAD_BEEF);
      reg_read(12'h400, rd); check("R3 unmapped read", rd, 32'h0);
      reg_read(12'h840, rd); check("R3 past table", rd, 32'h0);
      reg_read(12'h800, rd); check("R3 word0 untouched", rd, 32'h8001_8100);

      // R4 R5 R6 R7 R10 walk of 8 entries, with wrap
      tx_req = 32'h8000_0005;
      rx_req = 32'h0000_0012;
      reg_write(12'h000, 32'h8000_0007);
      for (int k = 0; k < 10; k++) begin
         @(negedge clk);
         check($sformatf("R4/R6 slot %0d vld", k), {31'b0, gnt_vld}, {31'b0, SLOT_EXP[k][6]});
         if (SLOT_EXP[k][6])
            check($sformatf("R5/R7 slot %0d ch/dir", k), {26'b0, gnt_rx, gnt_ch},
                  {26'b0, SLOT_EXP[k][5:0]});
      end
      reg_read(12'h000, rd); check("R2 ctrl readback", rd, 32'h8000_0007);

      // R8 disable
      tx_req = '1; rx_req = '1;
      reg_write(12'h000, 32'h0);
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         check("R8 no grant when off", {31'b0, gnt_vld}, 32'h0);
      end
      reg_read(12'h000, rd); check("R8 ctrl off", rd, 32'h0);

      // R8 R7 restart from entry 0 with a two-entry table
      reg_write(12'h000, 32'h8000_0001);
      @(negedge clk);
      check("R8 restart entry0", {30'b0, gnt_vld, gnt_rx, gnt_ch}, {26'b0, 7'b1_0_00000});
      @(negedge clk);
      check("R7 entry1", {25'b0, gnt_vld, gnt_rx, gnt_ch}, {25'b0, 7'b1_1_00001});
      @(negedge clk);
      check("R7 short wrap", {25'b0, gnt_vld, gnt_rx, gnt_ch}, {25'b0, 7'b1_0_00000});

      finish_run();
   end
endmodule